// File: doc/BRIEF.md
# Crystal Trim and Settle Sequencer

This block orders the start-up of a 16 MHz crystal oscillator. Once the oscillator enable goes high it waits a programmable number of 250 µs steps. It then copies the stored coarse and fine trim value onto its trim output. It waits a second programmable number of steps and then raises a settled flag. A second flag, trim-ready, tells the clock-switching logic that the trim driving the oscillator equals the value currently programmed.

Both delays count pulses of an external 250 µs tick, not system clock cycles. The first pulse can arrive at any point inside a step. A delay code of n therefore lasts between n-1 and n steps, and a code of zero skips that delay. If the stored trim changes after the sequence has settled, the new value is applied and the settle delay starts again. Dropping the enable sends the sequencer back to idle.

All pins are plain control and status levels. There is no data stream, so no valid/ready handshake and no back-pressure. The analog oscillator itself is outside the block.

Top module: `xtal_trim_seq`

## Requirements
- R1: After reset, `trim_out` is 0 and `trim_ready` and `settled` are low.
- R2: With `osc_en` high and a trim delay code n > 0, the stored trim is copied to `trim_out` on the edge that sees the n-th `step_tick` pulse. Counting starts with the first pulse after the edge at which the sequencer saw `osc_en` high in idle.
- R3: A trim delay code of 0 copies the stored trim on the same edge at which the sequencer first sees `osc_en` high.
- R4: A settle code m > 0 raises `settled` on the edge that sees the m-th `step_tick` pulse. Counting starts after the edge that applied the trim.
- R5: A settle code of 0 raises `settled` on the same edge that applies the trim.
- R6: `trim_out` is {coarse[2:0], fine[7:0]}: coarse in bits 10:8 and fine in bits 7:0. `trim_ready` is high exactly when a trim has been applied since the last enable and `trim_out` equals the present {`coarse_set`, `fine_set`}.
- R7: Only `step_tick` pulses advance either delay. Without pulses, the sequencer holds its phase indefinitely.
- R8: On the first edge with `osc_en` low, the sequencer goes to idle and clears `settled` and `trim_ready`. `trim_out` keeps its last value.
- R9: While settled, a change of the stored trim is applied on the next edge and the settle delay restarts. For that one cycle `trim_ready` is low and `settled` stays high.
- R10: Each delay code is sampled when its delay starts. Changing a code during a delay does not alter that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Crystal oscillator enable |
| step_tick | input | 1 | One-cycle pulse every 250 µs |
| settle_code | input | 4 | Settle delay in steps, 0 = none |
| trim_code | input | 8 | Trim delay in steps, 0 = none |
| fine_set | input | 8 | Stored fine trim, higher = faster |
| coarse_set | input | 3 | Stored coarse trim, higher = faster |
| trim_out | output | 11 | Applied trim {coarse, fine} |
| trim_ready | output | 1 | Applied trim equals stored trim |
| settled | output | 1 | Settle delay complete |

## Verification
A wrong phase or a wrong count in a step counter does not show up at once. It shows up at the ports only at the next `step_tick` pulse, when `trim_out` changes or `settled` rises one step early or one step late. A phase that is stuck, or that ignores the enable, shows up on the very next cycle as a flag that stays high after `osc_en` falls. A faulty applied-trim register or compare is seen at once on `trim_out` or `trim_ready`. The bench therefore compares all three outputs every cycle against a reference that moves only on tick pulses. It uses tick periods that differ from run to run and codes that change in the middle of a delay.

// File: rtl/xts_pkg.sv
package xts_pkg;
  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_TRIM   = 2'd1,
    XS_SETTLE = 2'd2,
    XS_DONE   = 2'd3
  } xts_state_e;
endpackage

// File: rtl/xts_step_cnt.sv
// Down-counter of step_tick pulses; expire flags the last pulse of a delay.
module xts_step_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == W'(1));

  p_hold_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/xts_trim_hold.sv
// Register holding the trim that drives the oscillator, plus the match compare.
module xts_trim_hold #(
  parameter int FW = 8,
  parameter int CW = 3,
  localparam int TW = FW + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  logic          clear,
  input  logic [FW-1:0] fine_in,
  input  logic [CW-1:0] coarse_in,
  output logic [TW-1:0] trim_out,
  output logic          ready
);
  logic          valid;
  logic [TW-1:0] stored;

  assign stored = {coarse_in, fine_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_out <= '0;
      valid    <= 1'b0;
    end else if (clear) begin
      valid    <= 1'b0;
    end else if (apply) begin
      trim_out <= stored;
      valid    <= 1'b1;
    end
  end

  assign ready = valid && (trim_out == stored);

  p_apply_captures_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !clear) |=> trim_out == $past(stored));
endmodule

// File: rtl/xts_fsm.sv
// Phase controller: idle -> trim wait -> settle wait -> settled.
module xts_fsm
  import xts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic trim_zero,
  input  logic settle_zero,
  input  logic expire,
  input  logic ready,
  output logic load,
  output logic sel_settle,
  output logic apply,
  output logic clear,
  output logic settled
);
  xts_state_e state, nxt;

  always_comb begin
    nxt        = state;
    load       = 1'b0;
    sel_settle = 1'b0;
    apply      = 1'b0;
    clear      = 1'b0;
    if (!osc_en) begin
      nxt   = XS_IDLE;
      clear = 1'b1;
    end else begin
      unique case (state)
        XS_IDLE: begin
          load = 1'b1;
          if (trim_zero) begin
            apply      = 1'b1;
            sel_settle = 1'b1;
            nxt        = settle_zero ? XS_DONE : XS_SETTLE;
          end else begin
            nxt = XS_TRIM;
          end
        end
        XS_TRIM: if (expire) begin
          apply      = 1'b1;
          load       = 1'b1;
          sel_settle = 1'b1;
          nxt        = settle_zero ? XS_DONE : XS_SETTLE;
        end
        XS_SETTLE: if (expire) nxt = XS_DONE;
        XS_DONE: if (!ready) begin
          apply      = 1'b1;
          load       = 1'b1;
          sel_settle = 1'b1;
          nxt        = settle_zero ? XS_DONE : XS_SETTLE;
        end
        default: nxt = XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= XS_IDLE;
    else        state <= nxt;
  end

  assign settled = (state == XS_DONE);

  p_off_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> state == XS_IDLE);
  p_settle_zero_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && settle_zero) |=> state == XS_DONE);
  p_trim_waits_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XS_TRIM && osc_en && !expire) |=> state == XS_TRIM);
endmodule

// File: rtl/xtal_trim_seq.sv
module xtal_trim_seq #(
  parameter int SETTLE_W = 4,
  parameter int TDLY_W   = 8,
  parameter int FINE_W   = 8,
  parameter int COARSE_W = 3,
  localparam int TRIM_W  = FINE_W + COARSE_W,
  localparam int CNT_W   = (SETTLE_W > TDLY_W) ? SETTLE_W : TDLY_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                osc_en,
  input  logic                step_tick,
  input  logic [SETTLE_W-1:0] settle_code,
  input  logic [TDLY_W-1:0]   trim_code,
  input  logic [FINE_W-1:0]   fine_set,
  input  logic [COARSE_W-1:0] coarse_set,
  output logic [TRIM_W-1:0]   trim_out,
  output logic                trim_ready,
  output logic                settled
);
  logic             load, sel_settle, apply, clear, expire;
  logic [CNT_W-1:0] load_val;

  assign load_val = sel_settle ? CNT_W'(settle_code) : CNT_W'(trim_code);

  xts_step_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .tick(step_tick), .expire(expire)
  );

  xts_trim_hold #(.FW(FINE_W), .CW(COARSE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .apply(apply), .clear(clear),
    .fine_in(fine_set), .coarse_in(coarse_set),
    .trim_out(trim_out), .ready(trim_ready)
  );

  xts_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
    .trim_zero(trim_code == '0), .settle_zero(settle_code == '0),
    .expire(expire), .ready(trim_ready),
    .load(load), .sel_settle(sel_settle), .apply(apply), .clear(clear),
    .settled(settled)
  );

  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!settled && !trim_ready));
endmodule

// File: tb/xtal_trim_seq_bench.sv
`timescale 1ns/1ps
module xtal_trim_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b0;
  logic        step_tick = 1'b0;
  logic [3:0]  settle_code = '0;
  logic [7:0]  trim_code = '0;
  logic [7:0]  fine_set = '0;
  logic [2:0]  coarse_set = '0;
  logic [10:0] trim_out;
  logic        trim_ready, settled;

  int vectors = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  xtal_trim_seq u_xtal_trim_seq (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .step_tick(step_tick),
    .settle_code(settle_code), .trim_code(trim_code),
    .fine_set(fine_set), .coarse_set(coarse_set),
    .trim_out(trim_out), .trim_ready(trim_ready), .settled(settled)
  );

  // Behavioural reference: phase 0 off, 1 trim wait, 2 settle wait, 3 settled.
  int          m_phase, m_left;
  logic [10:0] m_trim;
  bit          m_valid;

  task automatic m_apply();
    m_trim  <= {coarse_set, fine_set};
    m_valid <= 1'b1;
    if (settle_code == 0) m_phase <= 3;
    else begin m_phase <= 2; m_left <= settle_code; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_left <= 0; m_trim <= '0; m_valid <= 1'b0;
    end else if (!osc_en) begin
      m_phase <= 0; m_valid <= 1'b0;
    end else begin
      case (m_phase)
        0: if (trim_code == 0) m_apply();
           else begin m_phase <= 1; m_left <= trim_code; end
        1: if (step_tick) begin
             if (m_left == 1) m_apply(); else m_left <= m_left - 1;
           end
        2: if (step_tick) begin
             if (m_left == 1) m_phase <= 3; else m_left <= m_left - 1;
           end
        default: if (m_trim != {coarse_set, fine_set}) m_apply();
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_ready;
      exp_ready = m_valid && (m_trim == {coarse_set, fine_set});
      vectors++;
      if (trim_out !== m_trim || trim_ready !== exp_ready || settled !== (m_phase == 3)) begin
        fails++;
        $display("FAIL %s cyc %0d: got trim=%h rdy=%b set=%b expected trim=%h rdy=%b set=%b",
                 cur_req, cyc, trim_out, trim_ready, settled, m_trim, exp_ready, m_phase == 3);
      end
    end
  end

  task automatic run(int n, int period);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      step_tick = (period > 0) && (k % period == period - 1);
    end
    @(negedge clk); #1;
    step_tick = 1'b0;
  endtask

  task automatic chk(string req, logic [10:0] got, logic [10:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", {trim_ready, settled, trim_out[8:0]}, 11'h000);
    chk("R1", trim_out, 11'h000);

    // R2, R4, R6: delayed apply then delayed settle
    cur_req = "R2"; fine_set = 8'h5A; coarse_set = 3'd5; trim_code = 8'd3; settle_code = 4'd2;
    osc_en = 1'b1;
    run(12, 5);
    chk("R2", trim_out, 11'h000);
    cur_req = "R4";
    run(30, 5);
    chk("R4", settled, 1'b1);
    chk("R6", trim_out, 11'h55A);
    chk("R6", trim_ready, 1'b1);

    // R8: disable clears flags, keeps trim
    cur_req = "R8"; osc_en = 1'b0;
    run(3, 2);
    chk("R8", {settled, trim_ready}, 2'b00);
    chk("R8", trim_out, 11'h55A);

    // R3, R5: both delays zero
    cur_req = "R3"; trim_code = 8'd0; settle_code = 4'd0; fine_set = 8'hFF; coarse_set = 3'd7;
    osc_en = 1'b1;
    run(0, 0);
    chk("R3", trim_out, 11'h7FF);
    chk("R5", settled, 1'b1);

    // R7: no ticks, no progress
    cur_req = "R7"; osc_en = 1'b0;
    run(2, 0);
    trim_code = 8'd2; settle_code = 4'd1; osc_en = 1'b1;
    run(50, 0);
    chk("R7", {trim_ready, settled}, 2'b00);
    run(20, 4);
    chk("R7", settled, 1'b1);

    // R10: codes changed mid-delay are ignored for that delay
    cur_req = "R10"; osc_en = 1'b0;
    run(2, 0);
    trim_code = 8'd4; settle_code = 4'd3; osc_en = 1'b1;
    run(2, 0);
    trim_code = 8'd0; settle_code = 4'd0;
    run(6, 3);
    chk("R10", trim_ready, 1'b0);
    run(40, 3);
    chk("R10", settled, 1'b1);

    // R9: trim change while settled re-applies and restarts settle
    cur_req = "R9"; settle_code = 4'd2; fine_set = 8'h12;
    run(0, 0);
    chk("R9", trim_out, 11'h712);
    chk("R9", {trim_ready, settled}, 2'b10);
    run(20, 4);
    chk("R9", settled, 1'b1);

    // R6: mismatch drops trim_ready at once
    cur_req = "R6"; coarse_set = 3'd1; settle_code = 4'd3;
    #1;
    chk("R6", trim_ready, 1'b0);
    run(30, 2);
    chk("R6", trim_out, 11'h112);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule